// File: doc/BRIEF.md
# Saturating Vector Pack Unit

This block narrows two 256-bit operand vectors into one 256-bit result, halving the width of every element and clamping any value that does not fit into the narrower type. Four conversions are offered: 16-bit to 8-bit and 32-bit to 16-bit, each with either a signed or an unsigned destination range. Source elements are always read as signed two's-complement values.

The result is assembled independently in each 128-bit lane. Within a lane, the lower 64 bits hold the narrowed elements of operand A's matching lane and the upper 64 bits hold those of operand B's matching lane. A caller presents both operands and a mode with `in_valid` high. The narrowed vector and `out_valid` appear after the next rising clock edge. The result register keeps its value while no new request arrives.

Top module: `vpack_unit`

## Requirements
- R1: Result bits [63:0] hold the narrowed elements of `opnd_a` bits [127:0], and result bits [127:64] hold the narrowed elements of `opnd_b` bits [127:0].
- R2: Result bits [191:128] hold the narrowed elements of `opnd_a` bits [255:128], and result bits [255:192] hold the narrowed elements of `opnd_b` bits [255:128].
- R3: Within each 64-bit group, narrowed elements appear in ascending source index order, with source element 0 at the least significant position. A lane supplies 8 elements in the 16-to-8 modes and 4 elements in the 32-to-16 modes.
- R4: With `mode` = 2'b00 (signed 16-to-8), each signed 16-bit element is clamped to -128..127. Values in range pass through unchanged.
- R5: With `mode` = 2'b01 (signed 32-to-16), each signed 32-bit element is clamped to -32768..32767. Values in range pass through unchanged.
- R6: With `mode` = 2'b10 (unsigned 16-to-8), each signed 16-bit element below 0 becomes 0x00, each element above 255 becomes 0xFF, and other elements pass through.
- R7: With `mode` = 2'b11 (unsigned 32-to-16), each signed 32-bit element below 0 becomes 0x0000, each element above 65535 becomes 0xFFFF, and other elements pass through.
- R8: `result` and `out_valid` are registered. `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R9: While `in_valid` is low, `result` keeps its previous value, whatever the operands and mode do.
- R10: A synchronous active-low reset clears `out_valid` to 0 and `result` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe: operands and mode are sampled at the next rising edge |
| mode | input | 2 | Conversion select: bit 0 chooses 32-to-16 (1) or 16-to-8 (0); bit 1 chooses an unsigned (1) or signed (0) destination range |
| opnd_a | input | 256 | First source vector; supplies the lower half of each result lane |
| opnd_b | input | 256 | Second source vector; supplies the upper half of each result lane |
| out_valid | output | 1 | High for one cycle per accepted request |
| result | output | 256 | Narrowed and saturated vector |

## Verification
The only state in the block is the result register and the valid flag. A defect there shows up at the ports one edge after the request that should have loaded or held them: a stale or lost valid, or a result that changes while idle. A fault in the combinational narrowing shows up in that same cycle as a wrong byte or word. Because each 64-bit group comes from one operand lane, a crossed lane or a reversed order shifts recognisable element values to the wrong position. A wrong clamp threshold only becomes visible with inputs exactly at a limit and one step beyond it, so the checks use those values in every mode.

// File: rtl/vpack_pkg.sv
// Package: shared types for the saturating vector pack unit.
// Assumes: mode bit 0 selects the element width, bit 1 the destination range.
package vpack_pkg;

    typedef enum logic [1:0] {
        PK_S16_TO_8  = 2'b00,
        PK_S32_TO_16 = 2'b01,
        PK_U16_TO_8  = 2'b10,
        PK_U32_TO_16 = 2'b11
    } pack_mode_e;

    // True when the mode narrows 32-bit elements to 16 bits.
    function automatic logic mode_is_wide(input pack_mode_e m);
        return m[0];
    endfunction

    // True when the destination range is unsigned.
    function automatic logic mode_is_unsigned(input pack_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/vpack_sat.sv
// Module: vpack_sat
// Narrows one signed IN_W-bit value to IN_W/2 bits with saturation.
// Assumes: din is two's complement. In unsigned mode the output range is
// 0..2^OUT_W-1; in signed mode it is -2^(OUT_W-1)..2^(OUT_W-1)-1.
module vpack_sat #(
    parameter  int IN_W  = 16,
    localparam int OUT_W = IN_W / 2
) (
    input  logic [IN_W-1:0]  din,
    input  logic             unsigned_mode,
    output logic [OUT_W-1:0] dout
);

    logic sign_bit;
    logic s_over_hi;
    logic s_over_lo;
    logic u_over_hi;

    // Classify the value against the limits of both destination ranges.
    always_comb begin
        sign_bit  = din[IN_W-1];
        s_over_hi = !sign_bit && (|din[IN_W-2:OUT_W-1]);
        s_over_lo =  sign_bit && !(&din[IN_W-2:OUT_W-1]);
        u_over_hi = !sign_bit && (|din[IN_W-2:OUT_W]);
    end

    // Pick the clamped or truncated value for the selected range.
    always_comb begin
        if (unsigned_mode) begin
            if (sign_bit)       dout = '0;
            else if (u_over_hi) dout = '1;
            else                dout = din[OUT_W-1:0];
        end else begin
            if (s_over_hi)      dout = {1'b0, {(OUT_W-1){1'b1}}};
            else if (s_over_lo) dout = {1'b1, {(OUT_W-1){1'b0}}};
            else                dout = din[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/vpack_lane.sv
// Module: vpack_lane
// Builds one result lane: operand A's narrowed elements in the lower half,
// operand B's in the upper half, each in ascending element order.
// Assumes: LANE_W is a multiple of 64. Both widths are computed in parallel
// and the mode selects one.
module vpack_lane
    import vpack_pkg::*;
#(
    parameter int LANE_W = 128
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    input  pack_mode_e        mode,
    output logic [LANE_W-1:0] dout
);

    localparam int HALF_W = LANE_W / 2;
    localparam int N_HW   = LANE_W / 16;
    localparam int N_DW   = LANE_W / 32;

    logic              uns;
    logic [HALF_W-1:0] a_to8, b_to8, a_to16, b_to16;

    // Decode the destination range from the mode.
    always_comb uns = mode_is_unsigned(mode);

    for (genvar i = 0; i < N_HW; i++) begin : g_hw
        vpack_sat #(.IN_W(16)) u_sat_a (
            .din(a_lane[i*16 +: 16]), .unsigned_mode(uns), .dout(a_to8[i*8 +: 8]));
        vpack_sat #(.IN_W(16)) u_sat_b (
            .din(b_lane[i*16 +: 16]), .unsigned_mode(uns), .dout(b_to8[i*8 +: 8]));
    end

    for (genvar j = 0; j < N_DW; j++) begin : g_dw
        vpack_sat #(.IN_W(32)) u_sat_a (
            .din(a_lane[j*32 +: 32]), .unsigned_mode(uns), .dout(a_to16[j*16 +: 16]));
        vpack_sat #(.IN_W(32)) u_sat_b (
            .din(b_lane[j*32 +: 32]), .unsigned_mode(uns), .dout(b_to16[j*16 +: 16]));
    end

    // Concatenate the two operand halves for the selected element width.
    always_comb begin
        if (mode_is_wide(mode)) dout = {b_to16, a_to16};
        else                    dout = {b_to8,  a_to8};
    end

endmodule

// File: rtl/vpack_unit.sv
// Module: vpack_unit (top)
// Saturating pack of two vectors into one, one lane at a time, with a
// single register stage on the result and the valid flag.
// Assumes: VEC_W is a multiple of LANE_W. Synchronous active-low reset.
module vpack_unit
    import vpack_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);

    localparam int N_LANES = VEC_W / LANE_W;

    pack_mode_e       mode_e;
    logic [VEC_W-1:0] packed_next;

    // Convert the raw mode pins to the shared enum.
    always_comb mode_e = pack_mode_e'(mode);

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        vpack_lane #(.LANE_W(LANE_W)) u_lane (
            .a_lane(opnd_a[l*LANE_W +: LANE_W]),
            .b_lane(opnd_b[l*LANE_W +: LANE_W]),
            .mode  (mode_e),
            .dout  (packed_next[l*LANE_W +: LANE_W])
        );
    end

    // Output register: load on request, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= packed_next;
        end
    end

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    assert_s8_clamp_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && !opnd_a[15] && (|opnd_a[14:7]))
        |=> result[7:0] == 8'h7F);
    assert_s16_clamp_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01 && !opnd_a[31] && (|opnd_a[30:15]))
        |=> result[15:0] == 16'h7FFF);
    assert_u8_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10 && opnd_a[15]) |=> result[7:0] == 8'h00);
    assert_u16_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11 && opnd_b[31]) |=> result[79:64] == 16'h0000);

endmodule

// File: tb/vpack_unit_test.sv
module vpack_unit_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   mode;
    logic [255:0] opnd_a, opnd_b;
    logic         out_valid;
    logic [255:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    vpack_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
    );

    // Row: {mode[1:0], source value[31:0], expected narrow value[15:0]}
    localparam int NROWS = 18;
    localparam logic [49:0] TBL [NROWS] = '{
        {2'b00, 32'h0000_007F, 16'h007F}, {2'b00, 32'h0000_0080, 16'h007F},
        {2'b00, 32'h0000_FF80, 16'h0080}, {2'b00, 32'h0000_FF7F, 16'h0080},
        {2'b00, 32'h0000_FFFF, 16'h00FF},
        {2'b01, 32'h0000_7FFF, 16'h7FFF}, {2'b01, 32'h0000_8000, 16'h7FFF},
        {2'b01, 32'hFFFF_8000, 16'h8000}, {2'b01, 32'hFFFF_7FFF, 16'h8000},
        {2'b10, 32'h0000_00FF, 16'h00FF}, {2'b10, 32'h0000_0100, 16'h00FF},
        {2'b10, 32'h0000_0000, 16'h0000}, {2'b10, 32'h0000_FFFF, 16'h0000},
        {2'b11, 32'h0000_FFFF, 16'hFFFF}, {2'b11, 32'h0001_0000, 16'hFFFF},
        {2'b11, 32'hFFFF_FFFF, 16'h0000}, {2'b11, 32'h0000_1234, 16'h1234},
        {2'b01, 32'h0000_0042, 16'h0042}
    };

    // Behavioural model of the requirements: lane layout and clamping.
    function automatic logic [255:0] model(input logic [1:0] m,
                                           input logic [255:0] a,
                                           input logic [255:0] b);
        logic [255:0] r = '0;
        longint lo, hi, v;
        int ew, ne;
        ew = m[0] ? 32 : 16;
        ne = 128 / ew;
        if (m[1]) begin lo = 0; hi = (longint'(1) << (ew/2)) - 1; end
        else begin lo = -(longint'(1) << (ew/2 - 1)); hi = (longint'(1) << (ew/2 - 1)) - 1; end
        for (int ln = 0; ln < 2; ln++)
            for (int src = 0; src < 2; src++)
                for (int e = 0; e < ne; e++) begin
                    logic [31:0] raw;
                    raw = src == 0 ? a[ln*128 + e*ew +: 32] : b[ln*128 + e*ew +: 32];
                    if (ew == 16) v = longint'($signed(raw[15:0]));
                    else          v = longint'($signed(raw));
                    if (v < lo) v = lo;
                    if (v > hi) v = hi;
                    for (int k = 0; k < ew/2; k++)
                        r[ln*128 + src*64 + e*(ew/2) + k] = v[k];
                end
        return r;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request; return after the result is registered, at a negedge.
    task automatic issue(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = m; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [255:0] pa, pb, hold_val;
        rst_n = 1'b0; in_valid = 1'b0; mode = 2'b00; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", {255'b0, out_valid}, 256'd0);
        check("R10 result", result, '0);
        rst_n = 1'b1;

        // Table walk: R4..R7 boundary values replicated into every element
        for (int i = 0; i < NROWS; i++) begin
            logic [1:0]  m;
            logic [31:0] v;
            logic [15:0] e;
            logic [255:0] a, exp;
            {m, v, e} = TBL[i];
            if (m[0]) begin a = {8{v}};        exp = {16{e}}; end
            else      begin a = {16{v[15:0]}}; exp = {32{e[7:0]}}; end
            issue(m, a, a);
            check(m == 2'b00 ? "R4 clamp" : m == 2'b01 ? "R5 clamp" :
                  m == 2'b10 ? "R6 clamp" : "R7 clamp", result, exp);
            check("R8 valid after request", {255'b0, out_valid}, 256'd1);
        end

        // R1 R2 R3: distinct elements expose lane placement and order
        for (int i = 0; i < 16; i++) begin
            pa[i*16 +: 16] = 16'(i * 1237 - 9000);
            pb[i*16 +: 16] = 16'(i * 911 + 200);
        end
        for (int m = 0; m < 4; m++) begin
            issue(2'(m), pa, pb);
            check("R1 low lane groups",  {128'b0, result[127:0]},   {128'b0, model(2'(m), pa, pb) & {128'b0, {128{1'b1}}}});
            check("R2 high lane groups", {128'b0, result[255:128]}, {128'b0, model(2'(m), pa, pb) >> 128});
            check("R3 element order", result, model(2'(m), pa, pb));
        end

        // R9: hold while idle with changing operands and mode; R8 valid drops
        hold_val = result;
        @(negedge clk);
        opnd_a = ~pa; opnd_b = ~pb; mode = 2'b10;
        @(negedge clk);
        @(negedge clk);
        check("R9 result held", result, hold_val);
        check("R8 valid low when idle", {255'b0, out_valid}, 256'd0);

        // R10: reset in mid-operation clears state
        issue(2'b01, pa, pb);
        @(negedge clk);
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 reset clears result", result, '0);
        check("R10 reset clears valid", {255'b0, out_valid}, 256'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule